// File: doc/BRIEF.md
# Two-Port Tenure Arbiter

This block decides which of two requesters may use a shared memory controller: a processor-core port and an internal-bus port. A port that wins arbitration holds a tenure, during which it may complete several transactions in a row. It keeps the grant until it reaches its own programmable transaction limit, drops its request, or is preempted. The other port then gets the memory if it is asking.

A small register interface holds three things: the per-port transaction limits, a 2-bit priority code for each port, and a preemption enable. With preemption active, a waiting core request takes the memory from the bus port. This happens at the next transaction boundary and never in the middle of a transaction. The block contains only the arbitration, the tenure counting and the preemption. Memory timing and data paths belong to the surrounding logic.

Top module: `tenure_arb`

## Requirements
- R1: After reset both grants are low, the limit register (address 0) reads 0x11, the priority register (address 1) reads 0x5 and the control register (address 2) reads 0.
- R2: In the limit register, bits 3:0 hold the core limit and bits 7:4 hold the bus limit. Bits 31:8 read as zero whatever was written to them.
- R3: Grants come from a register, so a grant appears on the clock edge after the request is sampled, never in the same cycle. At most one grant is high, and a grant goes only to a port that was requesting in the previous cycle.
- R4: A limit field value of 1 to 15 allows that many transactions per tenure, and 0 allows 16. One transaction completes for each cycle in which the granted port's done input is high. When the last allowed transaction completes and the other port is requesting, the grant moves to the other port on that clock edge.
- R5: When a port reaches its limit and the other port is not requesting, the same port keeps the grant and starts a fresh count.
- R6: When the granted port drops its request, its grant falls at the next edge. If the other port is requesting, it receives the grant at that same edge.
- R7: When both ports have equal priority codes and both request from idle, tenures alternate between them. The core port wins the first such decision after reset.
- R8: When both ports request from idle with different priority codes, the numerically lower code wins. 00 is the highest priority. Priority codes sit in address 1: the core code in bits 1:0 and the bus code in bits 3:2.
- R9: Preemption is active when control bit 0 is set, the core priority code is 00 and the bus priority code is not 00. While it is active and the core is requesting, a completed bus transaction ends the bus tenure, and the core is granted at that edge.
- R10: When the preemption conditions of R9 are not all met, the enable has no effect, and the bus tenure runs to its limit.
- R11: A granted port that is still requesting and has not signalled done keeps its grant, whatever the other port does.
- R12: A done pulse from the port that does not hold the grant has no effect on the tenure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core port requests the memory |
| core_done | input | 1 | Core port completed one transaction this cycle |
| core_gnt | output | 1 | Core port holds the memory |
| bus_req | input | 1 | Internal-bus port requests the memory |
| bus_done | input | 1 | Bus port completed one transaction this cycle |
| bus_gnt | output | 1 | Bus port holds the memory |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |

## Verification
Every grant decision uses the request, done and configuration values sampled at one clock edge. The grants change at that same edge, so they can be observed one nanosecond after it. The bench drives all inputs just after an edge and reads the grants just after the next edge, so each check sees the result of exactly one decision. Register reads are combinational and are sampled one nanosecond after the address is set. A register write takes effect at the edge that captures the strobe, and the bench checks its effect from the following cycle onward.

// File: rtl/tarb_pkg.sv
package tarb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CORE = 2'd1,
        OWN_BUS  = 2'd2
    } owner_e;
endpackage

// File: rtl/tarb_regs.sv
module tarb_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 4,
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  core_lim_fld,
    output logic [CNT_W-1:0]  bus_lim_fld,
    output logic [PRIO_W-1:0] core_prio,
    output logic [PRIO_W-1:0] bus_prio,
    output logic              pre_en
);
    localparam int LIM_BITS  = 2 * CNT_W;
    localparam int PRIO_BITS = 2 * PRIO_W;

    typedef struct packed {
        logic [CNT_W-1:0]  core_lim;
        logic [CNT_W-1:0]  bus_lim;
        logic [PRIO_W-1:0] core_prio;
        logic [PRIO_W-1:0] bus_prio;
        logic              pre_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:LIM_BITS];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_W'(0): begin
                    cfg_d.core_lim = wdata[CNT_W-1:0];
                    cfg_d.bus_lim  = wdata[LIM_BITS-1:CNT_W];
                end
                ADDR_W'(1): begin
                    cfg_d.core_prio = wdata[PRIO_W-1:0];
                    cfg_d.bus_prio  = wdata[PRIO_BITS-1:PRIO_W];
                end
                ADDR_W'(2): cfg_d.pre_en = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.core_lim  <= CNT_W'(1);
            cfg_q.bus_lim   <= CNT_W'(1);
            cfg_q.core_prio <= PRIO_W'(1);
            cfg_q.bus_prio  <= PRIO_W'(1);
            cfg_q.pre_en    <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(0): rdata[LIM_BITS-1:0]  = {cfg_q.bus_lim, cfg_q.core_lim};
            ADDR_W'(1): rdata[PRIO_BITS-1:0] = {cfg_q.bus_prio, cfg_q.core_prio};
            ADDR_W'(2): rdata[0]             = cfg_q.pre_en;
            default: ;
        endcase
    end

    assign core_lim_fld = cfg_q.core_lim;
    assign bus_lim_fld  = cfg_q.bus_lim;
    assign core_prio    = cfg_q.core_prio;
    assign bus_prio     = cfg_q.bus_prio;
    assign pre_en       = cfg_q.pre_en;
endmodule

// File: rtl/tarb_limit.sv
module tarb_limit #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] fld,
    output logic [CNT_W:0]   lim
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    // a zero field stands for the full power-of-two count
    always_comb begin
        if (fld == '0) lim = FULL;
        else           lim = {1'b0, fld};
    end
endmodule

// File: rtl/tarb_pick.sv
module tarb_pick #(
    parameter int PRIO_W = 2
) (
    input  logic              core_req,
    input  logic              bus_req,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic [PRIO_W-1:0] bus_prio,
    input  logic              last_bus,
    output logic              pick_core,
    output logic              pick_bus
);
    always_comb begin
        pick_core = core_req;
        pick_bus  = bus_req;
        if (core_req && bus_req) begin
            if (core_prio < bus_prio) begin
                pick_bus = 1'b0;
            end else if (bus_prio < core_prio) begin
                pick_core = 1'b0;
            end else if (last_bus) begin
                pick_bus = 1'b0;
            end else begin
                pick_core = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tenure_arb.sv
module tenure_arb
    import tarb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 4,
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_done,
    output logic              core_gnt,
    input  logic              bus_req,
    input  logic              bus_done,
    output logic              bus_gnt,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int NPORT = 2;
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    typedef struct packed {
        owner_e         owner;
        logic [CNT_W:0] cnt;
        logic           last_bus;
    } arb_t;

    logic [CNT_W-1:0]  lim_fld [NPORT];
    logic [CNT_W:0]    lim     [NPORT];
    logic [PRIO_W-1:0] core_prio, bus_prio;
    logic              pre_en, pre_act;
    logic              pick_core, pick_bus;
    logic [CNT_W:0]    cnt_inc;
    arb_t              s_d, s_q;

    tarb_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .core_lim_fld(lim_fld[0]), .bus_lim_fld(lim_fld[1]),
        .core_prio(core_prio), .bus_prio(bus_prio), .pre_en(pre_en)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_lim
        tarb_limit #(.CNT_W(CNT_W)) i_lim (.fld(lim_fld[p]), .lim(lim[p]));
    end

    tarb_pick #(.PRIO_W(PRIO_W)) i_pick (
        .core_req(core_req), .bus_req(bus_req),
        .core_prio(core_prio), .bus_prio(bus_prio),
        .last_bus(s_q.last_bus),
        .pick_core(pick_core), .pick_bus(pick_bus)
    );

    assign pre_act = pre_en && (core_prio == '0) && (bus_prio != '0);
    assign cnt_inc = s_q.cnt + ONE;

    always_comb begin
        s_d = s_q;
        case (s_q.owner)
            OWN_CORE: begin
                if (!core_req) begin
                    s_d.cnt = '0;
                    if (bus_req) begin
                        s_d.owner    = OWN_BUS;
                        s_d.last_bus = 1'b1;
                    end else begin
                        s_d.owner = OWN_NONE;
                    end
                end else if (core_done) begin
                    if (cnt_inc >= lim[0]) begin
                        s_d.cnt = '0;
                        if (bus_req) begin
                            s_d.owner    = OWN_BUS;
                            s_d.last_bus = 1'b1;
                        end
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
            end
            OWN_BUS: begin
                if (!bus_req) begin
                    s_d.cnt = '0;
                    if (core_req) begin
                        s_d.owner    = OWN_CORE;
                        s_d.last_bus = 1'b0;
                    end else begin
                        s_d.owner = OWN_NONE;
                    end
                end else if (bus_done) begin
                    if (cnt_inc >= lim[1] || (pre_act && core_req)) begin
                        s_d.cnt = '0;
                        if (core_req) begin
                            s_d.owner    = OWN_CORE;
                            s_d.last_bus = 1'b0;
                        end
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
            end
            default: begin
                s_d.cnt = '0;
                if (pick_core) begin
                    s_d.owner    = OWN_CORE;
                    s_d.last_bus = 1'b0;
                end else if (pick_bus) begin
                    s_d.owner    = OWN_BUS;
                    s_d.last_bus = 1'b1;
                end else begin
                    s_d.owner = OWN_NONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.owner    <= OWN_NONE;
            s_q.cnt      <= '0;
            s_q.last_bus <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign core_gnt = (s_q.owner == OWN_CORE);
    assign bus_gnt  = (s_q.owner == OWN_BUS);
endmodule

// File: rtl/tarb_chk.sv
module tarb_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_req,
    input logic              core_done,
    input logic              core_gnt,
    input logic              bus_req,
    input logic              bus_done,
    input logic              bus_gnt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_gnt, bus_gnt}));

    // R3
    core_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_gnt) |-> $past(core_req));

    // R3
    bus_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_gnt) |-> $past(bus_req));

    // R6
    core_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && !core_req) |=> !core_gnt);

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && !bus_done) |=> bus_gnt);

    // R11
    core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && core_req && !core_done) |=> core_gnt);

    // R2
    lim_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:8] == '0));
endmodule

bind tenure_arb tarb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_tarb_chk (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_done(core_done), .core_gnt(core_gnt),
    .bus_req(bus_req), .bus_done(bus_done), .bus_gnt(bus_gnt),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_tenure_arb.sv
`timescale 1ns/1ps
module test_tenure_arb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        core_req, core_done, core_gnt;
    logic        bus_req, bus_done, bus_gnt;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tenure_arb i_tenure_arb (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_done(core_done), .core_gnt(core_gnt),
        .bus_req(bus_req), .bus_done(bus_done), .bus_gnt(bus_gnt),
        .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // grant code: 1 = core, 2 = bus, 0 = none
    task automatic chk_gnt(string tag, logic [1:0] exp);
        chk(tag, {30'd0, bus_gnt, core_gnt}, {30'd0, exp});
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic idle_all();
        core_req = 0; bus_req = 0; core_done = 0; bus_done = 0;
        tick();
        chk_gnt("idle", 2'd0);
    endtask

    task automatic t_reset();
        chk_gnt("R1 grants", 2'd0);
        rd_chk("R1 limits", 2'd0, 32'h11);
        rd_chk("R1 prio", 2'd1, 32'h5);
        rd_chk("R1 ctrl", 2'd2, 32'h0);
    endtask

    task automatic t_rr();
        core_req = 1; bus_req = 1;
        tick(); chk_gnt("R7 core first", 2'd1);
        core_done = 1; tick(); core_done = 0;
        chk_gnt("R7 alternate to bus", 2'd2);
        bus_done = 1; tick(); bus_done = 0;
        chk_gnt("R7 alternate to core", 2'd1);
        idle_all();
    endtask

    task automatic t_reserved();
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R2 reserved bits", 2'd0, 32'hFF);
    endtask

    task automatic t_limit();
        wr(2'd0, 32'h03);
        bus_req = 1;
        tick(); chk_gnt("R4 bus granted", 2'd2);
        core_req = 1; bus_done = 1;
        for (int i = 1; i <= 16; i++) begin
            tick();
            if (i == 15) chk_gnt("R4 bus after 15 of 16", 2'd2);
        end
        bus_done = 0;
        chk_gnt("R4 zero field means 16", 2'd1);
        core_done = 1;
        tick(); tick();
        chk_gnt("R4 core after 2 of 3", 2'd1);
        tick(); core_done = 0;
        chk_gnt("R4 core limit 3", 2'd2);
        idle_all();
    endtask

    task automatic t_fresh();
        wr(2'd0, 32'h02);
        core_req = 1;
        tick(); chk_gnt("R5 core granted", 2'd1);
        core_done = 1;
        tick(); tick();
        chk_gnt("R5 core keeps grant", 2'd1);
        bus_req = 1;
        tick(); chk_gnt("R5 fresh count 1", 2'd1);
        tick(); core_done = 0;
        chk_gnt("R5 fresh count 2 hands over", 2'd2);
        idle_all();
    endtask

    task automatic t_drop();
        core_req = 1;
        #1; chk_gnt("R3 no grant before edge", 2'd0);
        tick(); chk_gnt("R3 grant after edge", 2'd1);
        bus_req = 1;
        tick(); chk_gnt("R11 core holds", 2'd1);
        core_req = 0;
        tick(); chk_gnt("R6 drop passes to bus", 2'd2);
        bus_req = 0;
        tick(); chk_gnt("R6 drop to idle", 2'd0);
    endtask

    task automatic t_prio();
        wr(2'd1, 32'h6);
        core_req = 1; bus_req = 1;
        tick(); chk_gnt("R8 bus code lower", 2'd2);
        idle_all();
        wr(2'd1, 32'h4);
        core_req = 1; bus_req = 1;
        tick(); chk_gnt("R8 core code lower", 2'd1);
        idle_all();
    endtask

    task automatic t_preempt();
        wr(2'd0, 32'h01);
        wr(2'd1, 32'h4);
        wr(2'd2, 32'h1);
        bus_req = 1;
        tick(); chk_gnt("R9 bus granted", 2'd2);
        core_req = 1;
        tick(); tick(); tick();
        chk_gnt("R11 no preempt mid transaction", 2'd2);
        bus_done = 1; tick(); bus_done = 0;
        chk_gnt("R9 preempted at boundary", 2'd1);
        idle_all();
    endtask

    task automatic t_nopreempt();
        wr(2'd1, 32'h0);
        bus_req = 1;
        tick(); chk_gnt("R10 bus granted", 2'd2);
        core_req = 1; bus_done = 1; tick(); bus_done = 0;
        chk_gnt("R10 both high ignores enable", 2'd2);
        wr(2'd1, 32'h5);
        bus_done = 1; tick(); bus_done = 0;
        chk_gnt("R10 core not high ignores enable", 2'd2);
        idle_all();
        wr(2'd2, 32'h0);
    endtask

    task automatic t_ignore();
        wr(2'd0, 32'h21);
        bus_req = 1;
        tick(); chk_gnt("R12 bus granted", 2'd2);
        core_req = 1; core_done = 1;
        tick(); tick(); tick(); core_done = 0;
        chk_gnt("R12 core done ignored", 2'd2);
        bus_done = 1;
        tick(); chk_gnt("R12 bus count one", 2'd2);
        tick(); bus_done = 0;
        chk_gnt("R12 bus limit two", 2'd1);
        idle_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; core_req = 0; bus_req = 0; core_done = 0; bus_done = 0;
        reg_we = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_rr();
        t_reserved();
        t_limit();
        t_fresh();
        t_drop();
        t_prio();
        t_preempt();
        t_nopreempt();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule